// File: doc/BRIEF.md
# Switched-Tail Phase Sequencer

This block produces a repeating train of non-overlapping timing phases from a shift chain whose first stage is fed with the inverted value of its last stage. A chain of `STAGES` flops steps through `2*STAGES` distinct patterns. Each pattern is recognised by a single two-input AND of two neighbouring stages, so the block has `2*STAGES` phase outputs. Phase 0 belongs to the all-zero pattern, and exactly one phase is high at a time. The default build has three stages and six phases.

The chain moves one step on each clock edge at which `en` is high and holds its pattern otherwise. A synchronous clear loads a fixed pattern, which is all zeros by default. Some patterns of the chain cannot occur in normal operation: for three stages these are 010 and 101, which would otherwise circulate among themselves forever. A pattern counts as illegal when more than one neighbouring pair of stages differs. On the next edge an illegal pattern is replaced by all zeros, whether or not `en` is high. The chain then runs in the legal cycle. By default a held pattern keeps its phase shown. A build-time option forces all phases low after any edge at which `en` is low.

Top module: `johnson_phase_gen`

## Requirements
- R1: With `clr` high at a clock edge, `stage_o` takes `CLEAR_STATE` (all zeros by default) at that edge, and `phase_o` shows the decode of that pattern (only `phase_o[0]` for all zeros).
- R2: At an edge with `en` high, `clr` low and a legal pattern, `stage_o[0]` takes the inverse of `stage_o[STAGES-1]` and `stage_o[i]` takes the old `stage_o[i-1]`. For three stages, written as `stage_o[0],stage_o[1],stage_o[2]`, this gives 000, 100, 110, 111, 011, 001, then 000 again.
- R3: At an edge with `en` low, `clr` low and a legal pattern, `stage_o` keeps its value.
- R4: `phase_o[0]` = ~s0&~sN-1, `phase_o[N]` = s0&sN-1, `phase_o[k]` = s(k-1)&~sk and `phase_o[N+k]` = ~s(k-1)&sk for 1<=k<N. The registered phases change at the same edge as `stage_o`, and in the default mode exactly one is high in every legal pattern: `phase_o[p]` for sequence position p.
- R5: The sequence has exactly `2*STAGES` positions, and enabled steps from position `2*STAGES-1` wrap to position 0.
- R6: A pattern with more than one differing neighbour pair (010 or 101 for three stages) is replaced by all zeros at the next edge, whatever the value of `en`.
- R7: After such a correction the chain continues in the legal sequence, so the next enabled edge gives 100 (three stages).
- R8: With `MODE = PH_GATED`, every phase is low after an edge at which `en` was low, while `stage_o` still holds. The phases return at the next edge with `en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous active-high clear |
| en | input | 1 | Step enable |
| stage_o | output | STAGES | Chain stages, bit 0 is the first stage |
| phase_o | output | 2*STAGES | Registered one-hot phase outputs |

## Verification
The illegal patterns cannot be reached from the ports, because clear, shift and hold only ever produce legal patterns. The bench therefore builds extra instances whose clear pattern is 010 or 101. Releasing `clr` on those instances with `en` low shows that the correction does not wait for the enable, and the next enabled edge shows that the chain comes back into the normal sequence. One of these instances also selects the gated mode, so phase blanking is checked while the chain leaves the lock-up loop.

// File: rtl/johnson_pkg.sv
package johnson_pkg;
  typedef enum logic {
    PH_FOLLOW = 1'b0,
    PH_GATED  = 1'b1
  } phase_mode_e;
endpackage

// File: rtl/johnson_step.sv
module johnson_step #(
  parameter int STAGES = 3
) (
  input  logic [STAGES-1:0] cur_i,
  input  logic              en_i,
  output logic [STAGES-1:0] nxt_o,
  output logic              legal_o
);
  localparam int PAIRS = STAGES - 1;

  logic [PAIRS-1:0]  diff_w;
  logic [STAGES-1:0] shifted_w;

  assign shifted_w[0] = ~cur_i[STAGES-1];

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign diff_w[i]      = cur_i[i] ^ cur_i[i+1];
    assign shifted_w[i+1] = cur_i[i];
  end

  // a legal pattern has at most one boundary between ones and zeros
  assign legal_o = ($countones(diff_w) <= 1);

  always_comb begin
    if (!legal_o)  nxt_o = '0;
    else if (en_i) nxt_o = shifted_w;
    else           nxt_o = cur_i;
  end
endmodule

// File: rtl/johnson_decode.sv
module johnson_decode #(
  parameter int STAGES = 3
) (
  input  logic [STAGES-1:0]   stage_i,
  output logic [2*STAGES-1:0] phase_o
);
  // two patterns are told apart by the outermost stages
  assign phase_o[0]      = ~stage_i[0] & ~stage_i[STAGES-1];
  assign phase_o[STAGES] =  stage_i[0] &  stage_i[STAGES-1];

  // the others by the position of the single boundary
  for (genvar k = 1; k < STAGES; k++) begin : g_edge
    assign phase_o[k]        =  stage_i[k-1] & ~stage_i[k];
    assign phase_o[STAGES+k] = ~stage_i[k-1] &  stage_i[k];
  end
endmodule

// File: rtl/johnson_phase_gen.sv
module johnson_phase_gen
  import johnson_pkg::*;
#(
  parameter int                STAGES      = 3,
  parameter logic [STAGES-1:0] CLEAR_STATE = '0,
  parameter phase_mode_e       MODE        = PH_FOLLOW
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                en,
  output logic [STAGES-1:0]   stage_o,
  output logic [2*STAGES-1:0] phase_o
);
  localparam int PHASES = 2 * STAGES;

  logic [STAGES-1:0] stage_q, stage_d;
  logic              legal_w;
  logic [PHASES-1:0] dec_next_w, dec_clear_w, phase_q;

  johnson_step #(.STAGES(STAGES)) u_step (
    .cur_i   (stage_q),
    .en_i    (en),
    .nxt_o   (stage_d),
    .legal_o (legal_w)
  );

  johnson_decode #(.STAGES(STAGES)) u_dec_next (
    .stage_i (stage_d),
    .phase_o (dec_next_w)
  );

  johnson_decode #(.STAGES(STAGES)) u_dec_clear (
    .stage_i (CLEAR_STATE),
    .phase_o (dec_clear_w)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      stage_q <= CLEAR_STATE;
      phase_q <= dec_clear_w;
    end else begin
      stage_q <= stage_d;
      if (MODE == PH_GATED && !en) phase_q <= '0;
      else                         phase_q <= dec_next_w;
    end
  end

  assign stage_o = stage_q;
  assign phase_o = phase_q;

  AST_CLEAR_LOADS: assert property (@(posedge clk) clr |=> stage_q == CLEAR_STATE); // R1
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (clr)
    (en && legal_w) |=> $countones(stage_q ^ $past(stage_q)) == 1); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    (!en && legal_w) |=> $stable(stage_q)); // R3
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (clr)
    (legal_w && MODE == PH_FOLLOW) |-> $countones(phase_q) == 1); // R4
  AST_LOCK_BREAK: assert property (@(posedge clk) disable iff (clr)
    !legal_w |=> stage_q == '0); // R6
  AST_GATED_DARK: assert property (@(posedge clk) disable iff (clr)
    (MODE == PH_GATED && !en) |=> phase_q == '0); // R8
endmodule

// File: tb/johnson_phase_gen_bench.sv
`timescale 1ns/1ps
module johnson_phase_gen_bench;
  import johnson_pkg::*;
  localparam int N  = 3;
  localparam int NP = 2 * N;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  st_m, st_a, st_b;
  logic [NP-1:0] ph_m, ph_a, ph_b;

  johnson_phase_gen #(.STAGES(N)) u_johnson_phase_gen (
    .clk(clk), .clr(clr), .en(en), .stage_o(st_m), .phase_o(ph_m));
  johnson_phase_gen #(.STAGES(N), .CLEAR_STATE(3'b010), .MODE(PH_FOLLOW)) u_lock_a (
    .clk(clk), .clr(clr), .en(en), .stage_o(st_a), .phase_o(ph_a));
  johnson_phase_gen #(.STAGES(N), .CLEAR_STATE(3'b101), .MODE(PH_GATED)) u_lock_b (
    .clk(clk), .clr(clr), .en(en), .stage_o(st_b), .phase_o(ph_b));

  int tests = 0;
  int fails = 0;
  bit started = 0;
  bit finished = 0;

  // behavioural reference: sequence position per instance
  int pos_m = 0, pos_a = 0, pos_b = 0;
  bit bad_a = 0, bad_b = 0, dark_b = 0;

  function automatic logic [N-1:0] exp_state(int p);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = (p <= N) ? (i < p) : (i >= p - N);
    return s;
  endfunction

  function automatic logic [NP-1:0] exp_phase(int p);
    return NP'(1) << p;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (clr) begin
      pos_m <= 0; pos_a <= 0; pos_b <= 0;
      bad_a <= 1'b1; bad_b <= 1'b1; dark_b <= 1'b0;
    end else begin
      if (en) pos_m <= (pos_m + 1) % NP;                    // R5 wrap
      if (bad_a) begin bad_a <= 1'b0; pos_a <= 0; end        // R6
      else if (en) pos_a <= (pos_a + 1) % NP;                // R7
      if (bad_b) begin bad_b <= 1'b0; pos_b <= 0; end
      else if (en) pos_b <= (pos_b + 1) % NP;
      dark_b <= !en;                                         // R8
    end
  end

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%b exp=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R1 R2 R3 R5", "main stage", 16'(st_m), 16'(exp_state(pos_m)));
      chk("R1 R4", "main phase", 16'(ph_m), 16'(exp_phase(pos_m)));
      if (bad_a) chk("R1", "lock_a clear pattern", 16'(st_a), 16'(3'b010));
      else begin
        chk("R6 R7", "lock_a stage", 16'(st_a), 16'(exp_state(pos_a)));
        chk("R4 R7", "lock_a phase", 16'(ph_a), 16'(exp_phase(pos_a)));
      end
      if (bad_b) chk("R1", "lock_b clear pattern", 16'(st_b), 16'(3'b101));
      else begin
        chk("R6 R7", "lock_b stage", 16'(st_b), 16'(exp_state(pos_b)));
        chk("R8", "lock_b gated phase", 16'(ph_b),
            dark_b ? 16'(0) : 16'(exp_phase(pos_b)));
      end
    end
  end

  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    repeat (3) @(negedge clk);
    clr = 1'b0; en = 1'b0;        // correction edge with enable low (R6)
    @(negedge clk);
    en = 1'b1;                    // two full laps and more (R2, R5, R7)
    repeat (14) @(negedge clk);
    en = 1'b0;                    // hold (R3, R8)
    repeat (4) @(negedge clk);
    for (int c = 0; c < 80; c++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      en = lf[0];
      @(negedge clk);
    end
    en = 1'b1; clr = 1'b1;        // clear wins over enable (R1)
    @(negedge clk);
    clr = 1'b0; en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL R2 watchdog expired got=running exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule